// File: doc/BRIEF.md
# Mapped Interrupt Request Arbiter

This block watches 64 level-sensitive interrupt lines and presents at most one of them at a time to the processor as a single outstanding vector request. Lines 0 to 31 come from PCI slots; lines 32 to 63 come from onboard I/O devices. Each PCI group of four lines shares one mapping register. Each onboard line has its own mapping register. Bit 31 of every mapping register enables its source. The other 31 bits are fixed per register and can be read back.

Once a request is presented it stays until software removes it. Software can remove it by disabling the matching mapping register, or by writing into one of two clear windows. A PCI line that rises while its group is enabled takes over the request at once, even if another request is outstanding. An onboard line that rises is taken only while nothing is outstanding. While idle, the block scans every high and enabled line and picks the lowest index, so PCI lines win over onboard lines. After any software clear, the scan runs again on the next cycle.

Top module: `irq_map_arb`

## Requirements
- R1: After reset no request is outstanding: `req_vld_o`=0 and `req_id_o`=64, the "none" code. The mapping registers are readable. PCI map register k reads 0x7C0|(k<<2), onboard map register k reads 0x7E0+k, and bit 31 of every map register reads 0. The address windows are selected by `addr_i[11:8]`: 0x0 is the PCI map registers, indexed by `addr_i[5:3]` with `addr_i[7:6]`=0; 0x1 is the onboard map registers, indexed by `addr_i[7:3]`; 0x4 is the PCI clear window, indexed by `addr_i[7:5]`; 0x8 is the onboard clear window, indexed by `addr_i[7:3]`. A read of any other address returns 0.
- R2: A write to a mapping register changes only bit 31 (the enable). The other 31 bits read back unchanged.
- R3: PCI line i is enabled by PCI map register i>>2. A rising edge on an enabled PCI line makes that line the request on the next clock edge, and it replaces any request already outstanding.
- R4: A rising onboard line becomes the request only if no request is outstanding and its own map register is enabled. While another request is outstanding, the rise has no effect on the request.
- R5: While no request is outstanding, the lowest-index line that is high and enabled is taken, scanning PCI lines 0..31 before onboard lines 32..63.
- R6: A line whose enable is clear never becomes the request.
- R7: A request stays outstanding when its input falls. Only a software clear removes it.
- R8: Writing a map register with bit 31 = 0 removes the outstanding request when the request number equals the PCI map index k, or equals 32+k for onboard map register k. Any other request is left outstanding.
- R9: A write to the PCI clear window with group index g removes the outstanding request when the request number divided by 4 equals g.
- R10: A write to the onboard clear window with index k removes the outstanding request only when it equals 32+k exactly.
- R11: A software clear takes precedence in its own cycle. On the next cycle the scan of R5 raises any line that is still high and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Interrupt levels; 0..31 PCI, 32..63 onboard |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address (write and read) |
| wdata_i | input | 32 | Write data; bit 31 is the enable |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| req_vld_o | output | 1 | A request is outstanding |
| req_id_o | output | 7 | Outstanding source number, 64 when none |

## Verification
The hardest situations to reach are those where the outstanding request and the scan disagree. One example is a clear that lands while several lower and higher lines are still high. Another is a map write whose index happens to equal a PCI request number from a different group. The stimulus stacks requests on purpose: it raises line 32, then 30, then 29, so each PCI rise displaces the previous request. It then removes them one at a time, and the rescan must pick 29, then 30, then 32. The quirky match is reached by holding request 4 and writing PCI map register 4, which belongs to group 1's neighbour in address but not in function. A write to map register 1 must not clear request 4.

// File: rtl/irq_map_arb_pkg.sv
package irq_map_arb_pkg;
  localparam int unsigned MAP_FIXED_BASE = 32'h7C0;

  function automatic logic [30:0] pci_map_fixed(input int unsigned k);
    return 31'(MAP_FIXED_BASE | (k << 2));
  endfunction

  function automatic logic [30:0] obio_map_fixed(input int unsigned k, input int unsigned n_pci);
    return 31'((MAP_FIXED_BASE | n_pci) + k);
  endfunction

  typedef enum logic [3:0] {
    WIN_PCI_MAP  = 4'h0,
    WIN_OBIO_MAP = 4'h1,
    WIN_PCI_CLR  = 4'h4,
    WIN_OBIO_CLR = 4'h8
  } win_e;
endpackage

// File: rtl/irq_map_scan.sv
module irq_map_scan #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_map_arb_pkg::*;
#(
  parameter int unsigned N_PCI_GRP = 8,
  parameter int unsigned GRP_LINES = 4,
  parameter int unsigned N_OBIO    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned ID_W      = 7,
  localparam int unsigned N_PCI    = N_PCI_GRP * GRP_LINES,
  localparam int unsigned GRP_W    = $clog2(N_PCI_GRP),
  localparam int unsigned OBIO_W   = $clog2(N_OBIO),
  localparam int unsigned LINE_SH  = $clog2(GRP_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  input  logic [ID_W-1:0]      req_id_i,
  output logic [31:0]          rdata_o,
  output logic [N_PCI_GRP-1:0] pci_en_o,
  output logic [N_OBIO-1:0]    obio_en_o,
  output logic                 sw_clr_o
);
  logic [3:0]        win;
  logic [GRP_W-1:0]  pmap_idx, pclr_idx;
  logic [OBIO_W-1:0] omap_idx;
  logic              pmap_sel, omap_sel, pclr_sel, oclr_sel, aligned;
  logic              unused_bits;

  assign win      = addr_i[ADDR_W-1 -: 4];
  assign aligned  = (addr_i[2:0] == 3'b000);
  assign pmap_idx = addr_i[3 +: GRP_W];
  assign pclr_idx = addr_i[5 +: GRP_W];
  assign omap_idx = addr_i[3 +: OBIO_W];

  assign pmap_sel = aligned && (win == WIN_PCI_MAP) && (addr_i[7:3+GRP_W] == '0);
  assign omap_sel = aligned && (win == WIN_OBIO_MAP);
  assign pclr_sel = (win == WIN_PCI_CLR);
  assign oclr_sel = aligned && (win == WIN_OBIO_CLR);

  assign unused_bits = ^{wdata_i[30:0], addr_i[ADDR_W-5:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pci_en_o  <= '0;
      obio_en_o <= '0;
    end else if (wr_en_i) begin
      if (pmap_sel) pci_en_o[pmap_idx]  <= wdata_i[31];
      if (omap_sel) obio_en_o[omap_idx] <= wdata_i[31];
    end
  end

  logic [ID_W-1:0] obio_id;
  assign obio_id = ID_W'(N_PCI) + ID_W'(omap_idx);

  always_comb begin
    sw_clr_o = 1'b0;
    if (wr_en_i) begin
      if (pmap_sel && !wdata_i[31] && (req_id_i == ID_W'(pmap_idx))) sw_clr_o = 1'b1;
      if (omap_sel && !wdata_i[31] && (req_id_i == obio_id))         sw_clr_o = 1'b1;
      if (pclr_sel && ((req_id_i >> LINE_SH) == ID_W'(pclr_idx)))    sw_clr_o = 1'b1;
      if (oclr_sel && (req_id_i == obio_id))                         sw_clr_o = 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (pmap_sel) rdata_o = {pci_en_o[pmap_idx], pci_map_fixed(pmap_idx)};
    if (omap_sel) rdata_o = {obio_en_o[omap_idx], obio_map_fixed(omap_idx, N_PCI)};
  end
endmodule

// File: rtl/irq_map_arb.sv
module irq_map_arb
  import irq_map_arb_pkg::*;
#(
  parameter int unsigned N_PCI_GRP = 8,
  parameter int unsigned GRP_LINES = 4,
  parameter int unsigned N_OBIO    = 32,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned N_PCI    = N_PCI_GRP * GRP_LINES,
  localparam int unsigned N_SRC    = N_PCI + N_OBIO,
  localparam int unsigned ID_W     = $clog2(N_SRC + 1),
  localparam int unsigned PCI_W    = $clog2(N_PCI),
  localparam int unsigned SRC_W    = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              req_vld_o,
  output logic [ID_W-1:0]   req_id_o
);
  localparam logic [ID_W-1:0] ID_NONE = ID_W'(N_SRC);

  logic [N_PCI_GRP-1:0] pci_en;
  logic [N_OBIO-1:0]    obio_en;
  logic [N_SRC-1:0]     en_vec, pend_q, rise;
  logic                 sw_clr;
  logic [ID_W-1:0]      req_q, req_d;

  irq_map_regs #(
    .N_PCI_GRP(N_PCI_GRP), .GRP_LINES(GRP_LINES), .N_OBIO(N_OBIO),
    .ADDR_W(ADDR_W), .ID_W(ID_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .req_id_i (req_q),
    .rdata_o  (rdata_o),
    .pci_en_o (pci_en),
    .obio_en_o(obio_en),
    .sw_clr_o (sw_clr)
  );

  for (genvar g = 0; g < N_PCI; g++) begin : g_pci_en
    assign en_vec[g] = pci_en[g / GRP_LINES];
  end
  for (genvar j = 0; j < N_OBIO; j++) begin : g_obio_en
    assign en_vec[N_PCI + j] = obio_en[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= irq_i;
  end
  assign rise = irq_i & ~pend_q;

  logic             pci_hit;
  logic [PCI_W-1:0] pci_idx;
  logic             idle_hit;
  logic [SRC_W-1:0] idle_idx;

  irq_map_scan #(.N(N_PCI), .IDX_W(PCI_W)) u_pci_scan (
    .vec_i  (rise[N_PCI-1:0] & en_vec[N_PCI-1:0]),
    .found_o(pci_hit),
    .idx_o  (pci_idx)
  );

  irq_map_scan #(.N(N_SRC), .IDX_W(SRC_W)) u_idle_scan (
    .vec_i  (irq_i & en_vec),
    .found_o(idle_hit),
    .idx_o  (idle_idx)
  );

  // clear wins; PCI arrival preempts; otherwise scan only when idle
  always_comb begin
    req_d = req_q;
    if (sw_clr)                             req_d = ID_NONE;
    else if (pci_hit)                       req_d = ID_W'(pci_idx);
    else if ((req_q == ID_NONE) && idle_hit) req_d = ID_W'(idle_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= ID_NONE;
    else         req_q <= req_d;
  end

  assign req_vld_o = (req_q != ID_NONE);
  assign req_id_o  = req_q;
endmodule

// File: rtl/irq_map_arb_chk.sv
module irq_map_arb_chk #(
  parameter int unsigned N_PCI = 32,
  parameter int unsigned N_SRC = 64,
  parameter int unsigned ID_W  = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] irq_i,
  input logic             wr_en_i,
  input logic             req_vld_o,
  input logic [ID_W-1:0]  req_id_o,
  input logic [N_SRC-1:0] en_vec,
  input logic             sw_clr
);
  logic [N_SRC-1:0] en_q;
  logic [ID_W-1:0]  id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      id_q <= ID_W'(N_SRC);
    end else begin
      en_q <= en_vec;
      id_q <= req_id_o;
    end
  end

  // R1
  id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_id_o <= ID_W'(N_SRC));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_o && !wr_en_i && (irq_i[N_PCI-1:0] == '0) |=> $stable(req_id_o));

  // R9
  sw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr |=> !req_vld_o);

  // R6
  grant_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_o && (req_id_o != id_q) |-> en_q[req_id_o[ID_W-2:0]]);

  // R11
  rescan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_o && !sw_clr && (|(irq_i & en_vec)) |=> req_vld_o);
endmodule

bind irq_map_arb irq_map_arb_chk #(.N_PCI(N_PCI), .N_SRC(N_SRC), .ID_W(ID_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_i),
  .wr_en_i  (wr_en_i),
  .req_vld_o(req_vld_o),
  .req_id_o (req_id_o),
  .en_vec   (en_vec),
  .sw_clr   (sw_clr)
);

// File: tb/irq_map_arb_tb.sv
module irq_map_arb_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] irq_i = '0;
  logic        wr_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        req_vld_o;
  logic [6:0]  req_id_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  irq_map_arb u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .req_vld_o(req_vld_o), .req_id_o(req_id_o)
  );

  function automatic logic [11:0] a_pmap(int k); return 12'h000 | 12'(k << 3); endfunction
  function automatic logic [11:0] a_omap(int k); return 12'h100 | 12'(k << 3); endfunction
  function automatic logic [11:0] a_pclr(int g); return 12'h400 | 12'(g << 5); endfunction
  function automatic logic [11:0] a_oclr(int k); return 12'h800 | 12'(k << 3); endfunction

  task automatic chk_req(string tag, logic ev, int eid);
    n_chk++;
    if (req_vld_o !== ev || req_id_o !== 7'(eid)) begin
      n_fail++;
      $display("FAIL %s: vld/id %0b/%0d expected %0b/%0d", tag, req_vld_o, req_id_o, ev, eid);
    end
  endtask

  task automatic chk_rd(string tag, logic [11:0] a, logic [31:0 ] exp);
    addr_i = a;
    #2;
    n_chk++;
    if (rdata_o !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata %h expected %h", tag, rdata_o, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_irq(int n, logic v);
    @(negedge clk_i);
    irq_i[n] = v;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk_req("R1 reset idle", 1'b0, 64);
    chk_rd("R1 pci map 3", a_pmap(3), 32'h0000_07CC);
    chk_rd("R1 obio map 5", a_omap(5), 32'h0000_07E5);
    chk_rd("R1 unmapped addr", 12'h200, 32'h0);
  endtask

  task automatic t_map_write;
    wr(a_pmap(2), 32'hFFFF_FFFF);
    chk_rd("R2 pci map 2 set", a_pmap(2), 32'h8000_07C8);
    wr(a_pmap(2), 32'h0000_0000);
    chk_rd("R2 pci map 2 clr", a_pmap(2), 32'h0000_07C8);
    wr(a_pmap(1), 32'h8000_0000);
    chk_rd("R2 pci map 1", a_pmap(1), 32'h8000_07C4);
  endtask

  task automatic t_arrival;
    set_irq(6, 1'b1);
    chk_req("R3 line 6 taken", 1'b1, 6);
    set_irq(9, 1'b1);
    chk_req("R6 line 9 disabled", 1'b1, 6);
    wr(a_omap(3), 32'h8000_0000);
    set_irq(35, 1'b1);
    chk_req("R4 onboard rise while busy", 1'b1, 6);
    set_irq(5, 1'b1);
    chk_req("R3 pci preempts", 1'b1, 5);
    set_irq(5, 1'b0);
    chk_req("R7 fall keeps request", 1'b1, 5);
  endtask

  task automatic t_clear_windows;
    wr(a_pclr(1), 32'h0);
    chk_req("R9 pci group clear", 1'b0, 64);
    @(negedge clk_i);
    chk_req("R11 rescan lowest", 1'b1, 6);
    wr(a_oclr(0), 32'h0);
    chk_req("R10 onboard clear mismatch", 1'b1, 6);
    set_irq(6, 1'b0);
    wr(a_pclr(1), 32'h0);
    @(negedge clk_i);
    chk_req("R5 scan picks onboard 35", 1'b1, 35);
    wr(a_oclr(3), 32'h0);
    chk_req("R10 onboard clear match", 1'b0, 64);
    @(negedge clk_i);
    chk_req("R11 rescan onboard", 1'b1, 35);
    wr(a_omap(3), 32'h0);
    chk_req("R8 onboard map disable clears", 1'b0, 64);
    @(negedge clk_i);
    @(negedge clk_i);
    chk_req("R6 disabled stays idle", 1'b0, 64);
  endtask

  task automatic t_map_quirk;
    set_irq(4, 1'b1);
    chk_req("R3 line 4 taken", 1'b1, 4);
    wr(a_pmap(1), 32'h0);
    chk_req("R8 map 1 no match", 1'b1, 4);
    wr(a_pmap(4), 32'h0);
    chk_req("R8 map index equals request", 1'b0, 64);
    @(negedge clk_i);
    chk_req("R6 group 1 now disabled", 1'b0, 64);
    @(negedge clk_i);
    irq_i[4] = 1'b0; irq_i[9] = 1'b0; irq_i[35] = 1'b0;
  endtask

  task automatic t_priority;
    wr(a_omap(0), 32'h8000_0000);
    wr(a_pmap(7), 32'h8000_0000);
    set_irq(32, 1'b1);
    chk_req("R4 onboard taken when idle", 1'b1, 32);
    set_irq(30, 1'b1);
    chk_req("R3 line 30 preempts", 1'b1, 30);
    set_irq(29, 1'b1);
    chk_req("R3 line 29 preempts", 1'b1, 29);
    wr(a_pclr(7), 32'h0);
    @(negedge clk_i);
    chk_req("R5 lowest 29", 1'b1, 29);
    set_irq(29, 1'b0);
    wr(a_pclr(7), 32'h0);
    @(negedge clk_i);
    chk_req("R5 next 30", 1'b1, 30);
    set_irq(30, 1'b0);
    wr(a_pclr(7), 32'h0);
    @(negedge clk_i);
    chk_req("R5 pci before onboard then 32", 1'b1, 32);
  endtask

  task automatic t_mid_reset;
    chk_rd("R2 pci map 7 enabled", a_pmap(7), 32'h8000_07DC);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_req("R1 reset removes request", 1'b0, 64);
    chk_rd("R1 map 7 enable cleared", a_pmap(7), 32'h0000_07DC);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_map_write();
    t_arrival();
    t_clear_windows();
    t_map_quirk();
    t_priority();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule